// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Interrupt or DMA Event Routing

This block is one 32-bit timer channel. Its counter advances on count ticks. The ticks come from a chosen source (the system clock, the system clock divided by 16, or an external input pin) after an 8-bit prescaler. The channel has two modes. In capture mode it stores the count when a chosen edge arrives on a capture input. In compare mode it raises an event when a tick finds the count equal to a reference value. In that case the counter can restart from zero.

Every event sets a sticky flag. The flag drives an output pin, as a one-cycle pulse or as a toggle, and goes either to an interrupt line or to a DMA request. The DMA request is cleared by an acknowledge handshake. Software sets up the channel through a small synchronous register port. Writes take effect on the clock edge. Reads are combinational from the address.

Register map (address: meaning):
- 0: control, read/write. Bit 0 enables the channel. Bits 2:1 select the clock: 0 system, 1 system/16, 2 external, 3 stopped. Bit 3 selects the mode: 1 compare, 0 capture. Bits 5:4 select the capture edge: 0 none, 1 rising, 2 falling, 3 both. Bit 6 turns on restart. Bit 7 selects the output action: 1 toggle, 0 pulse. Bit 8 enables the event output. Bit 9 routes the event: 1 DMA, 0 interrupt. Bits 23:16 hold the prescaler.
- 1: reference, read/write.
- 2: captured count, read only.
- 3: live count, read only.
- 4: status. Bit 0 is the event flag, cleared by writing 1.

Top module: `cc_timer`

## Requirements
- R1: After reset the count, the captured value, the flag, `irq_o`, `dma_req_o` and `evt_o` are all 0.
- R2: While control bit 0 is 0, the count is held at 0. With the system clock and prescaler 0, the count equals the number of clock edges since the edge that wrote the enable.
- R3: A prescaler value N in control bits 23:16 gives one count tick for every N+1 source pulses.
- R4: Clock select 1 gives one source pulse every 16 system clocks.
- R5: Clock select 2 counts rising edges of `ext_clk_i` after a two-flop synchronizer.
- R6: In compare mode, a tick that finds the count equal to the reference sets the flag one cycle later. Without restart (bit 6 = 0) the counter keeps incrementing.
- R7: With restart (bit 6 = 1), the tick that matches loads the count with 0 instead of count+1.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 there leaves it unchanged. A new event wins over a clear in the same cycle.
- R9: When bit 8 is 1, the flag drives `irq_o` if bit 9 is 0 and `dma_req_o` if bit 9 is 1, never both. A one-cycle `dma_ack_i` clears the flag only when bit 9 is 1.
- R10: In pulse action (bit 7 = 0), `evt_o` is high for exactly the one cycle that follows each event.
- R11: In toggle action (bit 7 = 1), `evt_o` inverts in the cycle after each event.
- R12: In capture mode, the selected edge of `cap_i`, seen after a two-flop synchronizer, stores the current count into the captured register and sets the flag. An edge that is not selected has no effect. A rise at `cap_i` shows up as a capture of the count three edges later, minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ext_clk_i | input | 1 | External count clock (asynchronous) |
| cap_i | input | 1 | Capture input (asynchronous) |
| dma_ack_i | input | 1 | DMA acknowledge, clears the flag when DMA routing is on |
| evt_o | output | 1 | Event output pin (pulse or toggle) |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |

## Verification
The assertions check on every cycle that:
- each tick adds one to the count, or loads zero on a restart match;
- an event sets the flag;
- a DMA acknowledge clears the flag;
- a capture stores the count of that cycle;
- the output pin pulses or toggles after an event;
- the prescaler never gives two ticks in a row when its value is nonzero.

Only the bench scenarios can show the absolute rates: divide-by-16 spacing, the divide ratio of a given prescaler value, and counting of synchronized external edges. The same holds for the end-to-end capture latency through the synchronizer, for unselected edges being ignored, and for the routing of the flag to exactly one request line.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam logic [1:0] CLK_SYS = 2'd0;
  localparam logic [1:0] CLK_DIV = 2'd1;
  localparam logic [1:0] CLK_EXT = 2'd2;
  localparam logic [1:0] CLK_OFF = 2'd3;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_REF  = 3'd1;
  localparam logic [2:0] A_CAPT = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  // sel[0] picks rising edges, sel[1] picks falling edges
  function automatic logic edge_hit(input logic prev, input logic cur, input logic [1:0] sel);
    return (sel[0] & cur & ~prev) | (sel[1] & ~cur & prev);
  endfunction
endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] edge_sel,
  output logic       hit
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign hit = cct_pkg::edge_hit(prev_q, chain_q[STAGES-1], edge_sel);
endmodule

// File: rtl/cct_tick.sv
module cct_tick #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       sel,
  input  logic [PRE_W-1:0] presc,
  input  logic             ext_hit,
  output logic             tick
);
  import cct_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pcnt_q;
  logic             src_pulse;

  assign src_pulse = (sel == CLK_SYS) |
                     ((sel == CLK_DIV) & (&div_q)) |
                     ((sel == CLK_EXT) & ext_hit);
  assign tick = en & src_pulse & (pcnt_q == presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pcnt_q <= '0;
    end else begin
      if (!en || sel != CLK_DIV) div_q <= '0;
      else                       div_q <= div_q + 1'b1;
      if (!en)                   pcnt_q <= '0;
      else if (src_pulse)        pcnt_q <= (pcnt_q == presc) ? '0 : pcnt_q + 1'b1;
    end
  end

  // R3
  presc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc != '0) |=> (!tick || presc == '0));
endmodule

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8,
  parameter int DIV_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             ext_clk_i,
  input  logic             cap_i,
  input  logic             dma_ack_i,
  output logic             evt_o,
  output logic             irq_o,
  output logic             dma_req_o
);
  import cct_pkg::*;

  localparam int PRE_LSB = 16;

  logic [CNT_W-1:0] ctrl_q, ref_q, cnt_q, capt_q;
  logic             flag_q, out_q;

  logic             f_en, f_cmp, f_restart, f_toggle, f_evt_en, f_dma;
  logic [1:0]       f_clk, f_edge;
  logic [PRE_W-1:0] f_presc;

  assign f_en      = ctrl_q[0];
  assign f_clk     = ctrl_q[2:1];
  assign f_cmp     = ctrl_q[3];
  assign f_edge    = ctrl_q[5:4];
  assign f_restart = ctrl_q[6];
  assign f_toggle  = ctrl_q[7];
  assign f_evt_en  = ctrl_q[8];
  assign f_dma     = ctrl_q[9];
  assign f_presc   = ctrl_q[PRE_LSB +: PRE_W];

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c, input logic wrap);
    return wrap ? '0 : c + 1'b1;
  endfunction

  logic ext_hit, cap_edge, tick;
  logic cmp_hit, cap_hit, evt, w1c, ack_clr;

  cct_sync #(.STAGES(SYNC_N)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk_i), .edge_sel(2'b01), .hit(ext_hit));

  cct_sync #(.STAGES(SYNC_N)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_i), .edge_sel(f_edge), .hit(cap_edge));

  cct_tick #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(f_en), .sel(f_clk), .presc(f_presc),
    .ext_hit(ext_hit), .tick(tick));

  assign cmp_hit = f_cmp & tick & (cnt_q == ref_q);
  assign cap_hit = f_en & ~f_cmp & cap_edge;
  assign evt     = cmp_hit | cap_hit;
  assign w1c     = reg_wr & (reg_addr == A_STAT) & reg_wdata[0];
  assign ack_clr = dma_ack_i & f_dma;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ref_q  <= '0;
      cnt_q  <= '0;
      capt_q <= '0;
      flag_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
      if (reg_wr && reg_addr == A_REF)  ref_q  <= reg_wdata;
      if (!f_en)     cnt_q <= '0;
      else if (tick) cnt_q <= next_count(cnt_q, cmp_hit & f_restart);
      if (cap_hit)   capt_q <= cnt_q;
      flag_q <= evt | (flag_q & ~(w1c | ack_clr));
      out_q  <= f_toggle ? (out_q ^ evt) : evt;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_REF:   reg_rdata = ref_q;
      A_CAPT:  reg_rdata = capt_q;
      A_CNT:   reg_rdata = cnt_q;
      A_STAT:  reg_rdata = {{(CNT_W-1){1'b0}}, flag_q};
      default: reg_rdata = '0;
    endcase
  end

  assign evt_o     = out_q;
  assign irq_o     = flag_q & f_evt_en & ~f_dma;
  assign dma_req_o = flag_q & f_evt_en & f_dma;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_en && tick && !(cmp_hit && f_restart)) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && f_restart) |=> cnt_q == '0);
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);
  // R9
  dma_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack_i && dma_req_o && !evt) |=> !flag_q);
  // R12
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> capt_q == $past(cnt_q));
  // R10
  pulse_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !f_toggle) |=> evt_o);
  // R11
  toggle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && f_toggle) |=> evt_o != $past(evt_o));
endmodule

// File: tb/cc_timer_tb.sv
module cc_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_clk_i = 1'b0, cap_i = 1'b0, dma_ack_i = 1'b0;
  logic        evt_o, irq_o, dma_req_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cc_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk_i(ext_clk_i),
    .cap_i(cap_i), .dma_ack_i(dma_ack_i), .evt_o(evt_o), .irq_o(irq_o),
    .dma_req_o(dma_req_o));

  // control word built from the field layout in the brief
  function automatic logic [31:0] cfg(input int clk_sel, input bit cmp, input int edge_sel,
                                      input bit restart, input bit tog, input bit evt_en,
                                      input bit to_dma, input int presc);
    return 32'd1 | (32'(clk_sel) << 1) | (32'(cmp) << 3) | (32'(edge_sel) << 4) |
           (32'(restart) << 6) | (32'(tog) << 7) | (32'(evt_en) << 8) |
           (32'(to_dma) << 9) | (32'(presc) << 16);
  endfunction

  function automatic int ticks_after(input int pulses, input int presc);
    return pulses / (presc + 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wcyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic setup(input logic [31:0] c, input logic [31:0] refv);
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd1);
    wr(3'd1, refv);
    wr(3'd0, c);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd3, v); chk("R1 count", v, 0);
    rd(3'd2, v); chk("R1 capture", v, 0);
    rd(3'd4, v); chk("R1 flag", v, 0);
    chk("R1 outputs", {29'd0, irq_o, dma_req_o, evt_o}, 0);
  endtask

  task automatic t_sysclk;
    logic [31:0] v;
    setup(cfg(0, 0, 0, 0, 0, 0, 0, 0), 0);
    wcyc(25); rd(3'd3, v); chk("R2 sys count", v, 25);
    wr(3'd0, 32'd0);
    wcyc(1); rd(3'd3, v); chk("R2 disabled clear", v, 0);
    wcyc(5); rd(3'd3, v); chk("R2 disabled hold", v, 0);
  endtask

  task automatic t_presc;
    logic [31:0] v;
    setup(cfg(0, 0, 0, 0, 0, 0, 0, 3), 0);
    wcyc(40); rd(3'd3, v); chk("R3 presc 40", v, ticks_after(40, 3));
    wcyc(3);  rd(3'd3, v); chk("R3 presc 43", v, ticks_after(43, 3));
    wcyc(1);  rd(3'd3, v); chk("R3 presc 44", v, ticks_after(44, 3));
  endtask

  task automatic t_div16;
    logic [31:0] v;
    setup(cfg(1, 0, 0, 0, 0, 0, 0, 0), 0);
    wcyc(79); rd(3'd3, v); chk("R4 div16 79", v, 79 / 16);
    wcyc(1);  rd(3'd3, v); chk("R4 div16 80", v, 80 / 16);
  endtask

  task automatic t_ext(input int presc);
    logic [31:0] v;
    setup(cfg(2, 0, 0, 0, 0, 0, 0, presc), 0);
    for (int i = 0; i < 5; i++) begin
      ext_clk_i = 1'b1; wcyc(3);
      ext_clk_i = 1'b0; wcyc(3);
    end
    wcyc(4); rd(3'd3, v); chk("R5 ext count", v, ticks_after(5, presc));
  endtask

  task automatic t_cmp_pulse;
    logic [31:0] v;
    setup(cfg(0, 1, 0, 0, 0, 1, 0, 0), 4);
    wcyc(4); rd(3'd4, v); chk("R6 no flag before match", v, 0);
    wcyc(1); rd(3'd4, v); chk("R6 flag after match", v, 1);
    rd(3'd3, v); chk("R6 count continues", v, 5);
    chk("R9 irq routed", {30'd0, irq_o, dma_req_o}, 2);
    chk("R10 pulse high", evt_o, 1);
    wcyc(1); chk("R10 pulse one cycle", evt_o, 0);
    wr(3'd4, 32'd0); rd(3'd4, v); chk("R8 write 0 keeps flag", v, 1);
    dma_ack_i = 1'b1; wcyc(1); dma_ack_i = 1'b0;
    rd(3'd4, v); chk("R9 ack ignored on irq route", v, 1);
    wr(3'd4, 32'd1); rd(3'd4, v); chk("R8 write 1 clears", v, 0);
    chk("R8 irq cleared", irq_o, 0);
  endtask

  task automatic t_restart_toggle;
    logic [31:0] v;
    setup(cfg(0, 1, 0, 1, 1, 0, 0, 0), 2);
    wcyc(3); rd(3'd3, v); chk("R7 restart to zero", v, 0);
    chk("R11 toggle first", evt_o, 1);
    wcyc(1); rd(3'd3, v); chk("R7 counts after restart", v, 1);
    wcyc(2); chk("R11 toggle second", evt_o, 0);
    wcyc(3); chk("R11 toggle third", evt_o, 1);
    wr(3'd0, 32'd0);
  endtask

  task automatic t_dma;
    logic [31:0] v;
    setup(cfg(0, 1, 0, 0, 0, 1, 1, 0), 3);
    wcyc(4);
    chk("R9 dma routed", {30'd0, irq_o, dma_req_o}, 1);
    dma_ack_i = 1'b1; wcyc(1); dma_ack_i = 1'b0;
    rd(3'd4, v); chk("R9 ack clears flag", v, 0);
    chk("R9 dma request drops", dma_req_o, 0);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    setup(cfg(0, 0, 1, 0, 0, 1, 0, 0), 0);
    wcyc(5); cap_i = 1'b1;
    wcyc(4); rd(3'd4, v); chk("R12 rise sets flag", v, 1);
    rd(3'd2, v); chk("R12 rise capture", v, 7);
    wcyc(2); cap_i = 1'b0; wcyc(4);
    setup(cfg(0, 0, 2, 0, 0, 1, 0, 0), 0);
    wcyc(3); cap_i = 1'b1;
    wcyc(6); rd(3'd4, v); chk("R12 rise ignored in fall mode", v, 0);
    rd(3'd2, v); chk("R12 capture unchanged", v, 7);
    cap_i = 1'b0;
    wcyc(4); rd(3'd4, v); chk("R12 fall sets flag", v, 1);
    rd(3'd2, v); chk("R12 fall capture", v, 11);
    setup(cfg(0, 0, 0, 0, 0, 1, 0, 0), 0);
    cap_i = 1'b1; wcyc(5); cap_i = 1'b0; wcyc(5);
    rd(3'd4, v); chk("R12 no edge selected", v, 0);
  endtask

  initial begin
    wcyc(3);
    rst_n = 1'b1;
    wcyc(1);
    t_reset();
    t_sysclk();
    t_presc();
    t_div16();
    t_ext(0);
    t_ext(1);
    t_cmp_pulse();
    t_restart_toggle();
    t_dma();
    t_capture();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule